// File: doc/BRIEF.md
# Receive Bit-Stream Pattern Detector

This block sits behind a demodulator and watches the recovered serial data, one bit for each cycle on which the bit strobe is high. In the frequency-shift mode it raises one of three status flags when the bit stream has run long enough as all ones, as all zeros, or as a strict alternation of ones and zeros. Once a pattern ends, its flag is kept up for a fixed number of further bit times, so slow firmware polling still sees it. While a pattern keeps running, its flag stays set.

In the quadrature start-stop mode, the zeros flag becomes a line-break detector. It fires when the count of consecutive zero bits reaches twice the character length plus four. The character length is latched when the mode is entered and is clamped to a legal range. The other two flags are forced low in this mode. Any change of the mode input clears every counter and flag on the next clock edge. Received bits are then ignored until a set number of 1 ms ticks have passed.

Top module: `rx_pattern_detect`

## Requirements
- R1: With `mode`=0 (FSK), `flag_mark` goes to 1 on the strobe that delivers the 32nd consecutive 1 bit, and not on the 31st.
- R2: With `mode`=0, `flag_space` goes to 1 on the strobe that delivers the 32nd consecutive 0 bit, and not on the 31st.
- R3: With `mode`=0, `flag_alt` goes to 1 once 32 consecutive bits each differ from the bit before. A bit equal to its predecessor restarts the count, with that bit counted as the first of a new run.
- R4: After a pattern ends, its FSK flag stays 1 through the next 12 strobes that do not complete a qualifying run, and it clears on the 13th.
- R5: While a pattern keeps running past 32 bits, its flag stays 1 on every strobe without dropping.
- R6: A change of `mode` clears all three flags and all run counts on the next clock edge.
- R7: After a mode change, bit strobes are ignored until `HOLDOFF_TICKS` (default 1) pulses of `tick_1ms` have been seen.
- R8: With `mode`=1 (QAM start-stop), `flag_space` goes to 1 when 2N+4 consecutive zeros have been received. N is the value of `char_len` sampled on the cycle the mode changed, and later changes of `char_len` have no effect.
- R9: A `char_len` value below 7 is treated as 7, and a value above 12 is treated as 12.
- R10: With `mode`=1, `flag_space` clears on the strobe that delivers the first 1 bit.
- R11: With `mode`=1, `flag_mark` and `flag_alt` stay 0 whatever bits are received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe marking a valid received bit |
| rx_bit | input | 1 | Received data bit |
| mode | input | 1 | 0 = FSK pattern mode, 1 = QAM start-stop break mode |
| char_len | input | 4 | Bits per character N, including start, stop and parity |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| flag_mark | output | 1 | Continuous-ones flag (status bit 7) |
| flag_space | output | 1 | Continuous-zeros flag in FSK, break flag in QAM (status bit 8) |
| flag_alt | output | 1 | Alternating-pattern flag (status bit 9) |

## Verification
The bench builds the block with its default parameters: runs of 32 bits, a 12-bit hold, a hold-off of one tick and a 4-bit character length. These values put every boundary within a few dozen strobes. The bench probes each run one strobe short of the limit and then exactly at it. It checks the hold window on its last bit and on the first bit after it. It also covers the break threshold at the clamped upper length and at a length changed after the mode was entered. For the hold-off, it sends a long zero run before the tick arrives and checks that the run is ignored.

// File: rtl/rxpd_pkg.sv
package rxpd_pkg;

  typedef enum logic {
    RX_FSK    = 1'b0,
    RX_QAM_SS = 1'b1
  } rx_mode_e;

  function automatic int unsigned clamp_len(input int unsigned n,
                                            input int unsigned lo,
                                            input int unsigned hi);
    if (n < lo)      return lo;
    else if (n > hi) return hi;
    else             return n;
  endfunction

endpackage

// File: rtl/rxpd_flag_unit.sv
module rxpd_flag_unit #(
  parameter int CNT_W  = 6,
  parameter int SAT    = 32,
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              bit_en,
  input  logic              match,
  input  logic              seed,
  input  logic [CNT_W-1:0]  thr,
  input  logic [HOLD_W-1:0] hold,
  output logic              flag
);

  logic [CNT_W-1:0]  run_q;
  logic [CNT_W-1:0]  run_inc;
  logic [HOLD_W-1:0] hold_q;
  logic              flag_q;
  logic              qualify;

  always_comb begin
    run_inc = (run_q == CNT_W'(SAT)) ? run_q : run_q + 1'b1;
    qualify = match && (run_inc >= thr);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run_q  <= '0;
      hold_q <= '0;
      flag_q <= 1'b0;
    end else if (bit_en) begin
      run_q <= match ? run_inc : CNT_W'(seed);
      if (qualify) begin
        flag_q <= 1'b1;
        hold_q <= hold;
      end else if (flag_q) begin
        if (hold_q == '0) flag_q <= 1'b0;
        else              hold_q <= hold_q - 1'b1;
      end
    end
  end

  assign flag = flag_q;

  // R1, R2, R3: a flag only rises on a strobe carrying a matching bit
  p_rise_needs_strobe_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(bit_en && match));

  // R4: a flag only falls through clear or an exhausted hold on a strobe
  p_fall_after_hold_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(flag_q) && !$past(clr)) |-> $past(bit_en && hold_q == '0));

  // R5: the run count never passes its saturation point
  p_run_sat_r5: assert property (@(posedge clk) disable iff (rst)
    run_q <= CNT_W'(SAT));

endmodule

// File: rtl/rx_pattern_detect.sv
module rx_pattern_detect #(
  parameter int RUN_LEN       = 32,
  parameter int HOLD_BITS     = 12,
  parameter int HOLDOFF_TICKS = 1,
  parameter int N_W           = 4,
  parameter int N_MIN         = 7,
  parameter int N_MAX         = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bit_en,
  input  logic           rx_bit,
  input  logic           mode,
  input  logic [N_W-1:0] char_len,
  input  logic           tick_1ms,
  output logic           flag_mark,
  output logic           flag_space,
  output logic           flag_alt
);
  import rxpd_pkg::*;

  localparam int BRK_MAX = 2 * N_MAX + 4;
  localparam int SAT_V   = (RUN_LEN > BRK_MAX) ? RUN_LEN : BRK_MAX;
  localparam int CNT_W   = $clog2(SAT_V + 1);
  localparam int HOLD_W  = $clog2(HOLD_BITS + 1);
  localparam int HO_W    = $clog2(HOLDOFF_TICKS + 2);
  localparam int NUNIT   = 3;

  rx_mode_e         mode_q;
  logic             mode_chg;
  logic             is_fsk;
  logic [HO_W-1:0]  holdoff_q;
  logic [CNT_W-1:0] brk_thr_q;
  logic             prev_q;
  logic             prev_vld;
  logic             bit_ok;

  logic [NUNIT-1:0]  u_match, u_seed, u_en, u_clr, u_flag;
  logic [CNT_W-1:0]  u_thr  [NUNIT];
  logic [HOLD_W-1:0] u_hold [NUNIT];

  assign mode_chg = (rx_mode_e'(mode) != mode_q);
  assign is_fsk   = (mode_q == RX_FSK);
  assign bit_ok   = bit_en && (holdoff_q == '0) && !mode_chg;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= RX_FSK;
      holdoff_q <= '0;
      brk_thr_q <= CNT_W'(BRK_MAX);
      prev_q    <= 1'b0;
      prev_vld  <= 1'b0;
    end else if (mode_chg) begin
      mode_q    <= rx_mode_e'(mode);
      holdoff_q <= HO_W'(HOLDOFF_TICKS);
      brk_thr_q <= CNT_W'(2 * clamp_len(int'(char_len), N_MIN, N_MAX) + 4);
      prev_q    <= 1'b0;
      prev_vld  <= 1'b0;
    end else begin
      if (tick_1ms && holdoff_q != '0) holdoff_q <= holdoff_q - 1'b1;
      if (bit_ok) begin
        prev_q   <= rx_bit;
        prev_vld <= 1'b1;
      end
    end
  end

  always_comb begin
    // unit 0: ones, unit 1: zeros / break, unit 2: alternation
    u_match[0] = rx_bit;
    u_match[1] = !rx_bit;
    u_match[2] = prev_vld && (rx_bit != prev_q);
    u_seed     = 3'b100;
    u_en[0]    = bit_ok && is_fsk;
    u_en[1]    = bit_ok;
    u_en[2]    = bit_ok && is_fsk;
    u_clr[0]   = mode_chg || !is_fsk;
    u_clr[1]   = mode_chg;
    u_clr[2]   = mode_chg || !is_fsk;
    u_thr[0]   = CNT_W'(RUN_LEN);
    u_thr[1]   = is_fsk ? CNT_W'(RUN_LEN) : brk_thr_q;
    u_thr[2]   = CNT_W'(RUN_LEN);
    u_hold[0]  = HOLD_W'(HOLD_BITS);
    u_hold[1]  = is_fsk ? HOLD_W'(HOLD_BITS) : '0;
    u_hold[2]  = HOLD_W'(HOLD_BITS);
  end

  for (genvar g = 0; g < NUNIT; g++) begin : g_unit
    rxpd_flag_unit #(
      .CNT_W (CNT_W),
      .SAT   (SAT_V),
      .HOLD_W(HOLD_W)
    ) u_det (
      .clk   (clk),
      .rst   (rst),
      .clr   (u_clr[g]),
      .bit_en(u_en[g]),
      .match (u_match[g]),
      .seed  (u_seed[g]),
      .thr   (u_thr[g]),
      .hold  (u_hold[g]),
      .flag  (u_flag[g])
    );
  end

  assign flag_mark  = u_flag[0];
  assign flag_space = u_flag[1];
  assign flag_alt   = u_flag[2];

  // R6: one edge after a mode change every flag is low
  p_mode_clear_r6: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> (!flag_mark && !flag_space && !flag_alt));

  // R7: no flag can be up while the hold-off is still running
  p_holdoff_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (holdoff_q != '0) |-> (!flag_mark && !flag_space && !flag_alt));

  // R11: mark and alternation flags stay low in break mode
  p_qam_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (mode_q == RX_QAM_SS) |-> (!flag_mark && !flag_alt));

  // R9: the latched break limit stays inside the clamped range
  p_thr_range_r9: assert property (@(posedge clk) disable iff (rst)
    (brk_thr_q >= CNT_W'(2 * N_MIN + 4)) && (brk_thr_q <= CNT_W'(BRK_MAX)));

endmodule

// File: tb/tb_rx_pattern_detect.sv
module tb_rx_pattern_detect;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic       rx_bit = 1'b0;
  logic       mode = 1'b0;
  logic [3:0] char_len = 4'd10;
  logic       tick_1ms = 1'b0;
  logic       flag_mark, flag_space, flag_alt;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  rx_pattern_detect dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit), .mode(mode),
    .char_len(char_len), .tick_1ms(tick_1ms),
    .flag_mark(flag_mark), .flag_space(flag_space), .flag_alt(flag_alt)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic send(input logic b);
    @(negedge clk);
    bit_en = 1'b1;
    rx_bit = b;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic send_n(input logic b, input int n);
    for (int i = 0; i < n; i++) send(b);
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick_1ms = 1'b1;
    @(negedge clk);
    tick_1ms = 1'b0;
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk);
    mode = m;
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(flag_mark,  1'b0, "R6 reset mark");
    chk(flag_space, 1'b0, "R6 reset space");
    chk(flag_alt,   1'b0, "R6 reset alt");
  endtask

  task automatic t_ones();
    send_n(1'b1, 31);
    chk(flag_mark, 1'b0, "R1 31 ones");
    send(1'b1);
    chk(flag_mark, 1'b1, "R1 32 ones");
    for (int i = 0; i < 8; i++) begin
      send(1'b1);
      chk(flag_mark, 1'b1, "R5 ones continue");
    end
  endtask

  task automatic t_hold_and_zeros();
    for (int i = 0; i < 12; i++) begin
      send(1'b0);
      chk(flag_mark, 1'b1, "R4 within hold");
    end
    send(1'b0);
    chk(flag_mark, 1'b0, "R4 hold expired");
    send_n(1'b0, 18);
    chk(flag_space, 1'b0, "R2 31 zeros");
    send(1'b0);
    chk(flag_space, 1'b1, "R2 32 zeros");
  endtask

  task automatic t_break();
    @(negedge clk);
    mode = 1'b1;
    @(negedge clk);
    chk(flag_space, 1'b0, "R6 clear after mode change");
    chk(flag_mark,  1'b0, "R6 clear mark");
    send_n(1'b0, 40);
    chk(flag_space, 1'b0, "R7 bits ignored before tick");
    pulse_tick();
    send_n(1'b0, 23);
    chk(flag_space, 1'b0, "R8 23 zeros N=10");
    send(1'b0);
    chk(flag_space, 1'b1, "R8 24 zeros N=10");
    send(1'b1);
    chk(flag_space, 1'b0, "R10 first one clears break");
    send_n(1'b1, 40);
    chk(flag_mark, 1'b0, "R11 mark low in QAM");
    for (int i = 0; i < 40; i++) send(logic'(i % 2));
    chk(flag_alt, 1'b0, "R11 alt low in QAM");
  endtask

  task automatic t_clamp_latch();
    set_mode(1'b0);
    pulse_tick();
    char_len = 4'd15;
    set_mode(1'b1);
    char_len = 4'd7;
    pulse_tick();
    send_n(1'b0, 27);
    chk(flag_space, 1'b0, "R9 27 zeros clamp 12");
    send(1'b0);
    chk(flag_space, 1'b1, "R9 28 zeros clamp 12");
    set_mode(1'b0);
    pulse_tick();
    char_len = 4'd7;
    set_mode(1'b1);
    char_len = 4'd12;
    pulse_tick();
    send_n(1'b0, 17);
    chk(flag_space, 1'b0, "R8 17 zeros latched N=7");
    send(1'b0);
    chk(flag_space, 1'b1, "R8 18 zeros latched N=7");
  endtask

  task automatic t_alt();
    set_mode(1'b0);
    pulse_tick();
    for (int i = 0; i < 20; i++) send(logic'((i % 2) == 0));
    send(1'b0);
    for (int i = 0; i < 30; i++) send(logic'((i % 2) == 0));
    chk(flag_alt, 1'b0, "R3 restart 31 bits");
    send(1'b1);
    chk(flag_alt, 1'b1, "R3 32 alternating");
  endtask

  initial begin
    t_reset();
    t_ones();
    t_hold_and_zeros();
    t_break();
    t_clamp_latch();
    t_alt();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule